// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block lets an external controller read and write a bank of byte-wide registers over three wires: a frame-enable line, a serial clock and one shared data line. It runs on the chip's system clock and oversamples the three serial inputs through synchronizers. The shared line is exposed as a separate input, output and output-enable, so a pad cell outside the block can form the tri-state buffer.

The clock polarity is not fixed at design time. The block leaves power-down, or reset, in an armed state. At the first rise of enable after that, it records the serial clock level and picks its edges from it:
- If the clock is high, bits are sampled on rising edges and driven on falling edges.
- If the clock is low, the roles of the two edges swap.

The choice holds until the next power-down.

A frame has three parts. First comes a two-bit command, with the low bit first. Next comes a six-bit register address, with the high bit first. Then come any number of data bytes, with the high bit first. The address steps by one after each byte and wraps at the top of the bank. Power-down is a single input that aborts the interface. It does not touch register contents.

Top module: `ser_reg_slave`

## Requirements
- R1: After reset the data output enable is low and every register reads back as 0x00.
- R2: At the first rise of enable after reset or power-down, the slave records the serial clock level. A low level selects falling edges for sampling and rising edges for driving. A high level selects rising edges for sampling and falling edges for driving.
- R3: The edge selection stays unchanged by later frames, whatever the clock level at their enable rise, until power-down is asserted.
- R4: A frame carries two command bits in the order C0 then C1. Next come address bits A5 down to A0, then data bits D7 down to D0. C0=1 with C1=0 is a write. C0=0 with C1=1 is a read.
- R5: A written byte reaches its register only after its eighth data bit is sampled. A byte cut short by enable falling leaves the register unchanged.
- R6: After each full data byte, in both reads and writes, the address advances by one. It wraps from 63 to 0.
- R7: In a read, the slave presents each data bit from a transfer edge until at least the following sampling edge. A read cut short returns the leading bits of the addressed register, high bit first.
- R8: The command codes C0=C1=0 and C0=C1=1 change no register and never enable the data output during that frame.
- R9: The data output enable is high only during the data phase of a read. It drops in the same instant enable goes low, without waiting for a clock.
- R10: Asserting power-down releases the data line at once, aborts the frame and re-arms the edge selection. It leaves register contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pd_i | input | 1 | Power-down; high aborts the interface and re-arms edge selection |
| sen_i | input | 1 | Frame enable from the controller, high during a frame |
| sclk_i | input | 1 | Serial clock from the controller |
| sdio_i | input | 1 | Serial data from the shared line |
| sdio_o | output | 1 | Serial data driven toward the shared line |
| sdio_oe_o | output | 1 | Output enable for the shared line |

## Verification
The bench uses the default parameters: 6 address bits, 8 data bits and a two-stage synchronizer. With only 64 registers, one read frame can sweep the whole bank plus one byte, which checks the reset contents and the 63-to-0 wrap together. It drives the serial clock at eight system clocks per half period, which leaves room for the synchronizer delay between each transfer edge and the following sampling edge. Random frames run under both clock polarities. Directed frames cover polarity locking, truncated bytes, unknown commands and power-down in the middle of a read.

// File: rtl/ser_reg_pkg.sv
package ser_reg_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_WRITE,
    PH_READ,
    PH_SKIP
  } phase_e;

  // command as {C1, C0}
  localparam logic [1:0] CMD_WRITE = 2'b01;
  localparam logic [1:0] CMD_READ  = 2'b10;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe[g] <= '0;
        else if (g == 0) pipe[g] <= d_i;
        else pipe[g] <= pipe[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/ser_edge_sel.sv
module ser_edge_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_i,
  input  logic sen_rise_i,
  input  logic sclk_s_i,
  output logic sample_o,
  output logic xfer_o,
  output logic samp_rise_o,
  output logic armed_o
);
  logic sclk_q, armed_q, samp_rise_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else sclk_q <= sclk_s_i;
  end

  // polarity latched once per power-down interval
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q     <= 1'b1;
      samp_rise_q <= 1'b0;
    end else if (pd_i) begin
      armed_q <= 1'b1;
    end else if (sen_rise_i && armed_q) begin
      samp_rise_q <= sclk_s_i;
      armed_q     <= 1'b0;
    end
  end

  assign rise        = sclk_s_i & ~sclk_q;
  assign fall        = ~sclk_s_i & sclk_q;
  assign sample_o    = ~armed_q & (samp_rise_q ? rise : fall);
  assign xfer_o      = ~armed_q & (samp_rise_q ? fall : rise);
  assign samp_rise_o = samp_rise_q;
  assign armed_o     = armed_q;
endmodule

// File: rtl/ser_frame.sv
module ser_frame
  import ser_reg_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pd_i,
  input  logic          sen_i,
  input  logic          sen_rise_i,
  input  logic          sample_i,
  input  logic          xfer_i,
  input  logic          sdi_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          drive_o,
  output logic          sdo_o,
  output phase_e        phase_o,
  output logic [AW-1:0] addr_o
);
  localparam int MAXW = (AW > DW) ? AW : DW;
  localparam int CW   = $clog2(MAXW);
  localparam int IW   = $clog2(DW);

  phase_e        phase;
  logic [CW-1:0] cnt;
  logic          c0_q;
  logic [1:0]    cmd_q;
  logic [AW-1:0] addr;
  logic [DW-1:0] wsh, rbyte;
  logic [IW-1:0] bidx;
  logic          started, drive;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      c0_q    <= 1'b0;
      cmd_q   <= '0;
      addr    <= '0;
      wsh     <= '0;
      rbyte   <= '0;
      bidx    <= '0;
      started <= 1'b0;
      drive   <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (pd_i) begin
        phase   <= PH_IDLE;
        drive   <= 1'b0;
        started <= 1'b0;
      end else if (sen_rise_i) begin
        phase   <= PH_CMD;
        cnt     <= '0;
        drive   <= 1'b0;
        started <= 1'b0;
      end else if (!sen_i) begin
        phase   <= PH_IDLE;
        drive   <= 1'b0;
        started <= 1'b0;
      end else begin
        unique case (phase)
          PH_CMD: if (sample_i) begin
            if (cnt == '0) begin
              c0_q <= sdi_i;
              cnt  <= CW'(1);
            end else begin
              cmd_q <= {sdi_i, c0_q};
              cnt   <= '0;
              phase <= PH_ADDR;
            end
          end
          PH_ADDR: if (sample_i) begin
            addr <= {addr[AW-2:0], sdi_i};
            if (cnt == CW'(AW-1)) begin
              cnt <= '0;
              if (cmd_q == CMD_READ)       phase <= PH_READ;
              else if (cmd_q == CMD_WRITE) phase <= PH_WRITE;
              else                         phase <= PH_SKIP;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          PH_WRITE: if (sample_i) begin
            wsh <= {wsh[DW-2:0], sdi_i};
            if (cnt == CW'(DW-1)) begin
              wr_en   <= 1'b1;
              wr_addr <= addr;
              wr_data <= {wsh[DW-2:0], sdi_i};
              addr    <= addr + AW'(1);
              cnt     <= '0;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          PH_READ: if (xfer_i) begin
            if (!started || bidx == '0) begin
              rbyte   <= rd_data_i;
              bidx    <= IW'(DW-1);
              started <= 1'b1;
              drive   <= 1'b1;
              if (started) addr <= addr + AW'(1);
            end else begin
              bidx <= bidx - IW'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  // look one address ahead when the current byte is exhausted
  assign rd_addr_o = (started && bidx == '0) ? addr + AW'(1) : addr;
  assign sdo_o     = drive & rbyte[bidx];
  assign drive_o   = drive;
  assign wr_en_o   = wr_en;
  assign wr_addr_o = wr_addr;
  assign wr_data_o = wr_data;
  assign phase_o   = phase;
  assign addr_o    = addr;
endmodule

// File: rtl/ser_regbank.sv
module ser_regbank #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en_i) begin
      mem[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/ser_reg_slave.sv
module ser_reg_slave
  import ser_reg_pkg::*;
#(
  parameter int AW          = 6,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_i,
  input  logic sen_i,
  input  logic sclk_i,
  input  logic sdio_i,
  output logic sdio_o,
  output logic sdio_oe_o
);
  logic [2:0]    pins_s;
  logic          sen_s, sclk_s, sdi_s, sen_q, sen_rise;
  logic          sample, xfer, samp_rise, armed;
  logic          wr_en, drive, sdo;
  logic [AW-1:0] wr_addr, rd_addr, addr;
  logic [DW-1:0] wr_data, rd_data;
  phase_e        phase;

  ser_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sen_i, sclk_i, sdio_i}),
    .q_o   (pins_s)
  );

  assign {sen_s, sclk_s, sdi_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sen_q <= 1'b0;
    else sen_q <= sen_s;
  end
  assign sen_rise = sen_s & ~sen_q;

  ser_edge_sel u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pd_i       (pd_i),
    .sen_rise_i (sen_rise),
    .sclk_s_i   (sclk_s),
    .sample_o   (sample),
    .xfer_o     (xfer),
    .samp_rise_o(samp_rise),
    .armed_o    (armed)
  );

  ser_frame #(.AW(AW), .DW(DW)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pd_i      (pd_i),
    .sen_i     (sen_s),
    .sen_rise_i(sen_rise),
    .sample_i  (sample),
    .xfer_i    (xfer),
    .sdi_i     (sdi_s),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .drive_o   (drive),
    .sdo_o     (sdo),
    .phase_o   (phase),
    .addr_o    (addr)
  );

  ser_regbank #(.AW(AW), .DW(DW)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data)
  );

  // raw enable and power-down gate the pad so release needs no clock
  assign sdio_oe_o = drive & sen_i & ~pd_i;
  assign sdio_o    = sdo & sdio_oe_o;
endmodule

// File: rtl/ser_reg_slave_chk.sv
module ser_reg_slave_chk
  import ser_reg_pkg::*;
#(
  parameter int AW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pd_i,
  input logic          sdio_oe_o,
  input phase_e        phase,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] addr,
  input logic          armed,
  input logic          samp_rise
);
  assert_oe_in_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdio_oe_o |-> (phase == PH_READ));

  assert_lock_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed && !pd_i) |=> $stable(samp_rise));

  assert_write_from_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> $past(phase == PH_WRITE));

  assert_addr_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (addr == wr_addr + AW'(1)));

  assert_skip_no_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_SKIP) |=> !wr_en);

  assert_pd_rearms_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> armed);
endmodule

bind ser_reg_slave ser_reg_slave_chk #(.AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pd_i     (pd_i),
  .sdio_oe_o(sdio_oe_o),
  .phase    (phase),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .addr     (addr),
  .armed    (armed),
  .samp_rise(samp_rise)
);

// File: tb/sim_ser_reg_slave.sv
module sim_ser_reg_slave;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pd_i = 1'b0, sen_i = 1'b0, sclk_i = 1'b0, sdio_i = 1'b0;
  logic sdio_o, sdio_oe_o;

  ser_reg_slave u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pd_i(pd_i), .sen_i(sen_i),
    .sclk_i(sclk_i), .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe_o(sdio_oe_o)
  );

  always #5 clk = ~clk;

  logic [7:0] ref_mem [64];
  logic [7:0] wbuf [8];
  int   n_chk = 0, n_fail = 0;
  logic samp_rise_m = 1'b0;
  logic oe_seen;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  // one bit: transfer edge (if needed) then sampling edge
  task automatic bit_xfer(input logic b, output logic rx, output logic oe);
    logic pre;
    pre = samp_rise_m ? 1'b0 : 1'b1;
    if (sclk_i != pre) sclk_i = pre;
    sdio_i = b;
    half();
    rx = sdio_o;
    oe = sdio_oe_o;
    if (oe) oe_seen = 1'b1;
    sclk_i = ~pre;
    half();
  endtask

  task automatic begin_frame();
    oe_seen = 1'b0;
    sen_i = 1'b1;
    half();
  endtask

  task automatic end_frame();
    sen_i = 1'b0;
    #1;
    check(sdio_oe_o == 1'b0, "R9 release on enable low", sdio_oe_o, 0);
    half();
  endtask

  // code is {C1, C0}; C0 goes first
  task automatic send_head(input logic [1:0] code, input int a);
    logic rx, oe;
    bit_xfer(code[0], rx, oe);
    bit_xfer(code[1], rx, oe);
    for (int b = 5; b >= 0; b--) bit_xfer(a[b], rx, oe);
  endtask

  task automatic wr_frame(input logic [1:0] code, input int a, input int n, input int tail);
    logic rx, oe;
    begin_frame();
    send_head(code, a);
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) bit_xfer(wbuf[i][b], rx, oe);
      if (code == 2'b01) ref_mem[(a + i) % 64] = wbuf[i];
    end
    for (int b = 0; b < tail; b++) bit_xfer(wbuf[n][7-b], rx, oe);
    check(oe_seen == 1'b0, (code == 2'b01) ? "R9 no drive in write" : "R8 no drive on unknown code",
          oe_seen, 0);
    end_frame();
  endtask

  task automatic rd_frame(input int a, input int n, input int tail, input string req);
    logic rx, oe, all_oe;
    logic [7:0] got;
    begin_frame();
    send_head(2'b10, a);
    all_oe = 1'b1;
    for (int i = 0; i < n; i++) begin
      got = '0;
      for (int b = 7; b >= 0; b--) begin
        bit_xfer(1'b0, rx, oe);
        got = {got[6:0], rx};
        all_oe &= oe;
      end
      check(got == ref_mem[(a + i) % 64], req, got, ref_mem[(a + i) % 64]);
    end
    if (tail > 0) begin
      got = '0;
      for (int b = 0; b < tail; b++) begin
        bit_xfer(1'b0, rx, oe);
        got = {got[6:0], rx};
        all_oe &= oe;
      end
      check(got == 8'(ref_mem[(a + n) % 64] >> (8 - tail)), "R7 truncated read",
            got, ref_mem[(a + n) % 64] >> (8 - tail));
    end
    check(all_oe == 1'b1, "R9 drive in read data", all_oe, 1);
    end_frame();
  endtask

  task automatic power_cycle(input logic lvl);
    pd_i = 1'b1;
    half();
    pd_i = 1'b0;
    sclk_i = lvl;
    samp_rise_m = lvl;
    half();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    logic rx, oe;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 64; i++) ref_mem[i] = 8'h00;

    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    sclk_i = 1'b0;
    samp_rise_m = 1'b0;
    half();
    check(sdio_oe_o == 1'b0, "R1 output enable after reset", sdio_oe_o, 0);

    // R1/R6: sweep whole bank plus wrap, falling-edge sampling (R2)
    rd_frame(0, 65, 0, "R1 reset contents");

    // R4/R5: directed write then readback
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C;
    wr_frame(2'b01, 5, 2, 0);
    rd_frame(5, 2, 0, "R4 write/read order");

    // R6: wrap on write
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    wr_frame(2'b01, 62, 3, 0);
    rd_frame(63, 2, 0, "R6 address wrap");

    // R5: partial byte discarded
    wbuf[0] = 8'hFF;
    wr_frame(2'b01, 10, 0, 5);
    rd_frame(10, 1, 0, "R5 partial write discarded");

    // R7: truncated read
    rd_frame(5, 0, 3, "R7");
    rd_frame(6, 1, 5, "R7 second byte truncated");

    // R8: unknown codes
    wbuf[0] = 8'h5A; wbuf[1] = 8'hC3;
    wr_frame(2'b00, 20, 2, 0);
    wr_frame(2'b11, 20, 2, 0);
    rd_frame(20, 2, 0, "R8 unknown code no write");

    // R2/R10: power-down with clock high selects rising sampling, contents kept
    power_cycle(1'b1);
    rd_frame(5, 2, 0, "R10 contents kept over power-down");
    wbuf[0] = 8'h96;
    wr_frame(2'b01, 40, 1, 0);
    rd_frame(40, 1, 0, "R2 rising-edge sampling");

    // R3: later frame starts with clock low; selection must hold
    sclk_i = 1'b0;
    half();
    rd_frame(40, 1, 0, "R3 polarity locked");
    sclk_i = 1'b1;
    half();

    // R10: power-down during a read
    begin_frame();
    send_head(2'b10, 5);
    bit_xfer(1'b0, rx, oe);
    bit_xfer(1'b0, rx, oe);
    check(oe == 1'b1, "R9 driving before power-down", oe, 1);
    pd_i = 1'b1;
    #1;
    check(sdio_oe_o == 1'b0, "R10 release on power-down", sdio_oe_o, 0);
    half();
    sen_i = 1'b0;
    half();
    pd_i = 1'b0;
    sclk_i = 1'b0;
    samp_rise_m = 1'b0;
    half();
    rd_frame(5, 1, 0, "R10 re-armed to falling sampling");

    // random frames under both polarities
    for (int k = 0; k < 40; k++) begin
      int a, n, op;
      if (k % 10 == 9) power_cycle(1'($urandom_range(0, 1)));
      a  = $urandom_range(0, 63);
      n  = $urandom_range(1, 4);
      op = $urandom_range(0, 2);
      if (op == 0) rd_frame(a, n, 0, "R6 random read");
      else begin
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
        wr_frame(2'b01, a, n, 0);
        rd_frame(a, n, 0, "R4 random readback");
      end
    end

    summary();
  end
endmodule